// File: doc/BRIEF.md
# SDRAM Command Sequence Decoder

This block accepts one memory access request at a time for a four-bank SDRAM and expands it into a short, fixed series of SDRAM commands. A read or write request carries a bank, a row, a column, a burst length and a path code. The path code tells the block whether the bank first needs a precharge and an activate, only an activate, or neither because the right row is already open. A refresh request expands into a precharge of all banks followed by an auto-refresh.

Every command waits for its own enable input, which an external timing checker drives to cover all cross-command timing. The block itself counts only two waits: precharge to activate (TRP cycles) and activate to the first read or write (TRCD cycles). Commands leave the block as single-cycle pulses, with the bank, the row or column, and the burst length alongside. A read or write is atomic. Once it has been issued, the request is complete and the block returns to idle.

After an auto-refresh, all banks are closed. The next read or write request therefore always begins with an activate, whatever its path code says.

Top module: `sdram_cmd_seq`

## Requirements
- R1: A read/write request follows one chain, selected by reqPath. A value of 0 gives read/write only, 1 gives activate then read/write, and 2 or 3 gives precharge, then activate, then read/write. Every command in the chain addresses the request's bank. reqWrite=1 selects write and reqWrite=0 selects read.
- R2: A request with reqRefresh=1 issues a precharge-all and then an auto-refresh. The auto-refresh comes no earlier than TRP cycles after the precharge-all. With its enables high, it comes exactly TRP cycles after.
- R3: An activate that follows a precharge comes no earlier than TRP cycles after it. With the enables high, it comes exactly TRP cycles after.
- R4: A read or write that follows an activate comes no earlier than TRCD cycles after it. With the enables high, it comes exactly TRCD cycles after.
- R5: A command is issued only in a cycle in which its enable is high: enPreAll, enRefr, or bit [bank] of enPre, enAct, enRead or enWrite. While the enable is low the chain waits, and it issues in the first cycle the enable is high once the local wait is over.
- R6: reqReady is high only in idle. A request is taken on a cycle with reqValid and reqReady both high. reqReady rises in the cycle after the read, write or auto-refresh is issued.
- R7: After an auto-refresh, the next read/write request begins with an activate, whatever its path code. Requests after that one follow their path codes again.
- R8: An activate drives the row on cmdAddr. A read or write drives the column, zero-extended, on cmdAddr and the burst field unchanged on cmdBurst. The burst field uses a minus-one code, so 0 means one beat.
- R9: At most one command pulse is high in any cycle.
- R10: A high clr returns the block to idle in the next cycle with the wait counter at zero, and it suppresses commands in the cycle it is high.
- R11: After reset, the block is idle with reqReady high and no command pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear to idle |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request taken this cycle if valid |
| reqRefresh | input | 1 | 1 = refresh request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPath | input | 2 | 0 rw only, 1 act+rw, 2/3 pre+act+rw |
| reqBank | input | 2 | Bank number |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Column address |
| reqBurst | input | BURST_W | Burst length minus one |
| enPreAll | input | 1 | Precharge-all allowed |
| enRefr | input | 1 | Auto-refresh allowed |
| enPre | input | 4 | Per-bank precharge allowed |
| enAct | input | 4 | Per-bank activate allowed |
| enRead | input | 4 | Per-bank read allowed |
| enWrite | input | 4 | Per-bank write allowed |
| cmdPre | output | 1 | Precharge pulse |
| cmdPreAll | output | 1 | Precharge-all pulse |
| cmdAct | output | 1 | Activate pulse |
| cmdRead | output | 1 | Read pulse |
| cmdWrite | output | 1 | Write pulse |
| cmdRefr | output | 1 | Auto-refresh pulse |
| cmdBank | output | 2 | Bank of the current command |
| cmdAddr | output | max(ROW_W,COL_W) | Row for activate, column for read/write |
| cmdBurst | output | BURST_W | Burst length minus one |

## Verification
A corrupted state register shows up at once as a command pulse in the wrong cycle, as a missing step in a chain, or as reqReady staying low. The bench compares each cycle of every chain against a schedule worked out from the path code and the refresh history. A wrong value in the wait counter moves the activate or the read/write away from exactly TRP or TRCD cycles, so the first mismatched cycle of that chain exposes it. A lost refresh flag shows as a read/write with no activate before it on the first request after a refresh. Holding enables low shows whether the chain stalls instead of issuing anyway.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_ACT,
    S_RW,
    S_PREALL,
    S_REFR
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic loadTrp;
    logic loadTrcd;
    logic selRow;
    logic clear;
  } dpStrobe_t;

  localparam logic [1:0] PATH_RW  = 2'd0;
  localparam logic [1:0] PATH_ACT = 2'd1;

endpackage

// File: rtl/sdram_seq_datapath.sv
module sdram_seq_datapath
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int BURST_W = 3,
  parameter int TRP     = 3,
  parameter int TRCD    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                reqWrite,
  input  logic [1:0]          reqBank,
  input  logic [ROW_W-1:0]    reqRow,
  input  logic [COL_W-1:0]    reqCol,
  input  logic [BURST_W-1:0]  reqBurst,
  output logic [1:0]          latBank,
  output logic                latWrite,
  output logic                cntZero,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmdAddr,
  output logic [BURST_W-1:0]  cmdBurst
);

  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int CNT_MAX = (TRP > TRCD) ? TRP : TRCD;
  localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;
  localparam logic [CNT_W-1:0] TRP_LOAD  = CNT_W'(TRP - 1);
  localparam logic [CNT_W-1:0] TRCD_LOAD = CNT_W'(TRCD - 1);

  logic [ROW_W-1:0]   latRow;
  logic [COL_W-1:0]   latCol;
  logic [BURST_W-1:0] latBurst;
  logic [CNT_W-1:0]   waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latBank  <= '0;
      latWrite <= 1'b0;
      latRow   <= '0;
      latCol   <= '0;
      latBurst <= '0;
    end else if (strobe.capture) begin
      latBank  <= reqBank;
      latWrite <= reqWrite;
      latRow   <= reqRow;
      latCol   <= reqCol;
      latBurst <= reqBurst;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitCnt <= '0;
    else if (strobe.clear)    waitCnt <= '0;
    else if (strobe.loadTrp)  waitCnt <= TRP_LOAD;
    else if (strobe.loadTrcd) waitCnt <= TRCD_LOAD;
    else if (waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
  end

  assign cntZero  = (waitCnt == '0);
  assign cmdAddr  = strobe.selRow ? ADDR_W'(latRow) : ADDR_W'(latCol);
  assign cmdBurst = latBurst;

  // R3 R4: the wait counter never exceeds its largest load value
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= CNT_W'(CNT_MAX - 1));

  // R10: a clear leaves the counter at zero
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> cntZero);

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int TRP  = 3,
  parameter int TRCD = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clr,
  input  logic       reqValid,
  input  logic       reqRefresh,
  input  logic [1:0] reqPath,
  input  logic [1:0] latBank,
  input  logic       latWrite,
  input  logic       cntZero,
  input  logic       enPreAll,
  input  logic       enRefr,
  input  logic [3:0] enPre,
  input  logic [3:0] enAct,
  input  logic [3:0] enRead,
  input  logic [3:0] enWrite,
  output logic       reqReady,
  output dpStrobe_t  strobe,
  output logic       cmdPre,
  output logic       cmdPreAll,
  output logic       cmdAct,
  output logic       cmdRead,
  output logic       cmdWrite,
  output logic       cmdRefr
);

  seqState_t state, stateNext;
  logic afterRefr, afterRefrNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      afterRefr <= 1'b0;
    end else begin
      state     <= stateNext;
      afterRefr <= afterRefrNext;
    end
  end

  always_comb begin
    stateNext     = state;
    afterRefrNext = afterRefr;
    strobe        = '0;
    cmdPre        = 1'b0;
    cmdPreAll     = 1'b0;
    cmdAct        = 1'b0;
    cmdRead       = 1'b0;
    cmdWrite      = 1'b0;
    cmdRefr       = 1'b0;
    reqReady      = (state == S_IDLE) && !clr;
    if (clr) begin
      stateNext     = S_IDLE;
      afterRefrNext = 1'b0;
      strobe.clear  = 1'b1;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (reqValid) begin
            strobe.capture = 1'b1;
            if (reqRefresh) begin
              stateNext = S_PREALL;
            end else begin
              afterRefrNext = 1'b0;
              if (afterRefr)                stateNext = S_ACT;
              else if (reqPath == PATH_RW)  stateNext = S_RW;
              else if (reqPath == PATH_ACT) stateNext = S_ACT;
              else                          stateNext = S_PRE;
            end
          end
        end
        S_PRE: begin
          if (enPre[latBank]) begin
            cmdPre         = 1'b1;
            strobe.loadTrp = 1'b1;
            stateNext      = S_ACT;
          end
        end
        S_ACT: begin
          strobe.selRow = 1'b1;
          if (cntZero && enAct[latBank]) begin
            cmdAct          = 1'b1;
            strobe.loadTrcd = 1'b1;
            stateNext       = S_RW;
          end
        end
        S_RW: begin
          if (cntZero) begin
            if (latWrite && enWrite[latBank]) begin
              cmdWrite  = 1'b1;
              stateNext = S_IDLE;
            end else if (!latWrite && enRead[latBank]) begin
              cmdRead   = 1'b1;
              stateNext = S_IDLE;
            end
          end
        end
        S_PREALL: begin
          if (enPreAll) begin
            cmdPreAll      = 1'b1;
            strobe.loadTrp = 1'b1;
            stateNext      = S_REFR;
          end
        end
        S_REFR: begin
          if (cntZero && enRefr) begin
            cmdRefr       = 1'b1;
            afterRefrNext = 1'b1;
            stateNext     = S_IDLE;
          end
        end
        default: stateNext = S_IDLE;
      endcase
    end
  end

  // ---------------- checker state: spacing between commands ----------------
  localparam int GAP_MAX = ((TRP > TRCD) ? TRP : TRCD) + 1;
  localparam int GAP_W   = $clog2(GAP_MAX + 1) + 1;
  localparam logic [1:0] K_NONE = 2'd0, K_PRE = 2'd1, K_ACT = 2'd2;

  logic [GAP_W-1:0] gapCnt;
  logic [1:0]       lastKind;
  logic             refrSeen;
  logic             anyCmd;

  assign anyCmd = cmdPre | cmdPreAll | cmdAct | cmdRead | cmdWrite | cmdRefr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= '0;
      lastKind <= K_NONE;
      refrSeen <= 1'b0;
    end else begin
      if (anyCmd) gapCnt <= GAP_W'(1);
      else if (gapCnt < GAP_W'(GAP_MAX)) gapCnt <= gapCnt + 1'b1;
      if (clr)                      lastKind <= K_NONE;
      else if (cmdPre || cmdPreAll) lastKind <= K_PRE;
      else if (cmdAct)              lastKind <= K_ACT;
      else if (anyCmd)              lastKind <= K_NONE;
      if (clr || cmdAct) refrSeen <= 1'b0;
      else if (cmdRefr)  refrSeen <= 1'b1;
    end
  end

  p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdPre, cmdPreAll, cmdAct, cmdRead, cmdWrite, cmdRefr}));

  p_pre_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdPre |-> enPre[latBank]);
  p_act_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdAct |-> enAct[latBank]);
  p_rd_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdRead |-> enRead[latBank]);
  p_wr_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite |-> enWrite[latBank]);
  p_pa_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdPreAll |-> enPreAll);
  p_refr_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdRefr |-> enRefr);

  p_trp_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAct && lastKind == K_PRE) |-> gapCnt >= GAP_W'(TRP));
  p_refr_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRefr && lastKind == K_PRE) |-> gapCnt >= GAP_W'(TRP));
  p_trcd_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdRead || cmdWrite) && lastKind == K_ACT) |-> gapCnt >= GAP_W'(TRCD));

  p_no_rw_after_refr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead || cmdWrite) |-> !refrSeen);

  p_ready_after_done_r6: assert property (@(posedge clk) disable iff (!rstN || clr)
    (cmdRead || cmdWrite || cmdRefr) |=> reqReady);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int BURST_W = 3,
  parameter int TRP     = 3,
  parameter int TRCD    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clr,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqRefresh,
  input  logic                reqWrite,
  input  logic [1:0]          reqPath,
  input  logic [1:0]          reqBank,
  input  logic [ROW_W-1:0]    reqRow,
  input  logic [COL_W-1:0]    reqCol,
  input  logic [BURST_W-1:0]  reqBurst,
  input  logic                enPreAll,
  input  logic                enRefr,
  input  logic [3:0]          enPre,
  input  logic [3:0]          enAct,
  input  logic [3:0]          enRead,
  input  logic [3:0]          enWrite,
  output logic                cmdPre,
  output logic                cmdPreAll,
  output logic                cmdAct,
  output logic                cmdRead,
  output logic                cmdWrite,
  output logic                cmdRefr,
  output logic [1:0]          cmdBank,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmdAddr,
  output logic [BURST_W-1:0]  cmdBurst
);

  dpStrobe_t  strobe;
  logic [1:0] latBank;
  logic       latWrite;
  logic       cntZero;

  sdram_seq_ctrl #(.TRP(TRP), .TRCD(TRCD)) u_ctrl (
    .clk(clk), .rstN(rstN), .clr(clr),
    .reqValid(reqValid), .reqRefresh(reqRefresh), .reqPath(reqPath),
    .latBank(latBank), .latWrite(latWrite), .cntZero(cntZero),
    .enPreAll(enPreAll), .enRefr(enRefr), .enPre(enPre), .enAct(enAct),
    .enRead(enRead), .enWrite(enWrite),
    .reqReady(reqReady), .strobe(strobe),
    .cmdPre(cmdPre), .cmdPreAll(cmdPreAll), .cmdAct(cmdAct),
    .cmdRead(cmdRead), .cmdWrite(cmdWrite), .cmdRefr(cmdRefr)
  );

  sdram_seq_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BURST_W(BURST_W), .TRP(TRP), .TRCD(TRCD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqWrite(reqWrite), .reqBank(reqBank), .reqRow(reqRow),
    .reqCol(reqCol), .reqBurst(reqBurst),
    .latBank(latBank), .latWrite(latWrite), .cntZero(cntZero),
    .cmdAddr(cmdAddr), .cmdBurst(cmdBurst)
  );

  assign cmdBank = latBank;

endmodule

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ROW_W = 13, COL_W = 10, BURST_W = 3, TRP = 3, TRCD = 2;
  localparam int ADDR_W = 13;

  typedef struct packed {
    logic              refresh;
    logic              write;
    logic [1:0]        path;
    logic [1:0]        bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [BURST_W-1:0] burst;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 2'd2, 2'd1, 13'h01A5, 10'h03C, 3'd3},
    '{1'b0, 1'b0, 2'd1, 2'd2, 13'h00F0, 10'h155, 3'd0},
    '{1'b0, 1'b1, 2'd0, 2'd3, 13'h0000, 10'h2AA, 3'd7},
    '{1'b1, 1'b0, 2'd0, 2'd0, 13'h0000, 10'h000, 3'd0},
    '{1'b0, 1'b0, 2'd0, 2'd0, 13'h1234, 10'h001, 3'd1},
    '{1'b0, 1'b1, 2'd2, 2'd2, 13'h0777, 10'h3FF, 3'd2},
    '{1'b0, 1'b0, 2'd3, 2'd1, 13'h1FFF, 10'h100, 3'd5},
    '{1'b1, 1'b1, 2'd2, 2'd3, 13'h0001, 10'h001, 3'd1},
    '{1'b0, 1'b0, 2'd2, 2'd3, 13'h0ABC, 10'h0C3, 3'd4}
  };

  logic clk = 1'b0, rstN = 1'b0, clr = 1'b0;
  logic reqValid = 1'b0, reqReady, reqRefresh = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqPath = '0, reqBank = '0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic [BURST_W-1:0] reqBurst = '0;
  logic enPreAll = 1'b1, enRefr = 1'b1;
  logic [3:0] enPre = 4'hF, enAct = 4'hF, enRead = 4'hF, enWrite = 4'hF;
  logic cmdPre, cmdPreAll, cmdAct, cmdRead, cmdWrite, cmdRefr;
  logic [1:0] cmdBank;
  logic [ADDR_W-1:0] cmdAddr;
  logic [BURST_W-1:0] cmdBurst;
  logic [5:0] cmdVec;

  int checks = 0, failures = 0;
  bit benchAfterRefr = 0;

  always #2.5 clk = ~clk;
  assign cmdVec = {cmdPre, cmdPreAll, cmdAct, cmdRead, cmdWrite, cmdRefr};

  sdram_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .BURST_W(BURST_W),
                  .TRP(TRP), .TRCD(TRCD)) dut (
    .clk(clk), .rstN(rstN), .clr(clr), .reqValid(reqValid), .reqReady(reqReady),
    .reqRefresh(reqRefresh), .reqWrite(reqWrite), .reqPath(reqPath),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqBurst(reqBurst),
    .enPreAll(enPreAll), .enRefr(enRefr), .enPre(enPre), .enAct(enAct),
    .enRead(enRead), .enWrite(enWrite),
    .cmdPre(cmdPre), .cmdPreAll(cmdPreAll), .cmdAct(cmdAct), .cmdRead(cmdRead),
    .cmdWrite(cmdWrite), .cmdRefr(cmdRefr), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .cmdBurst(cmdBurst)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic driveReq(input vec_t v);
    reqValid   = 1'b1;
    reqRefresh = v.refresh;
    reqWrite   = v.write;
    reqPath    = v.path;
    reqBank    = v.bank;
    reqRow     = v.row;
    reqCol     = v.col;
    reqBurst   = v.burst;
  endtask

  // one table entry with all enables high; schedule derived from R1..R7
  task automatic runVec(input vec_t v, input int idx);
    int tPre = -1, tAct = -1, tRw = -1, tPa = -1, tRf = -1, last;
    int eff;
    bit seqOk = 1, fldOk = 1, oneOk = 1, busyOk = 1;
    logic [5:0] exp, badGot = '0, badExp = '0;
    string req;
    if (v.refresh) begin
      tPa = 1; tRf = 1 + TRP; last = tRf; req = "R2";
      benchAfterRefr = 1;
    end else begin
      eff = benchAfterRefr ? 1 : (v.path == 2'd0 ? 0 : (v.path == 2'd1 ? 1 : 2));
      req = benchAfterRefr ? "R7" : "R1 R3 R4";
      benchAfterRefr = 0;
      if (eff == 2) begin tPre = 1; tAct = 1 + TRP; tRw = tAct + TRCD; end
      else if (eff == 1) begin tAct = 1; tRw = 1 + TRCD; end
      else tRw = 1;
      last = tRw;
    end
    step();
    chk(reqReady === 1'b1 && cmdVec === 6'b0, "R6", $sformatf("vec%0d idle before", idx),
        {reqReady, cmdVec}, 7'b1000000);
    driveReq(v);
    for (int off = 1; off <= last; off++) begin
      @(negedge clk);
      reqValid = 1'b0;
      #1;
      exp = (off == tPre) ? 6'b100000 : (off == tPa) ? 6'b010000 :
            (off == tAct) ? 6'b001000 :
            (off == tRw)  ? (v.write ? 6'b000010 : 6'b000100) :
            (off == tRf)  ? 6'b000001 : 6'b000000;
      if (cmdVec !== exp && seqOk) begin seqOk = 0; badGot = cmdVec; badExp = exp; end
      if ($countones(cmdVec) > 1) oneOk = 0;
      if (reqReady !== 1'b0) busyOk = 0;
      if ((off == tPre || off == tAct || off == tRw) && cmdBank !== v.bank) fldOk = 0;
      if (off == tAct && cmdAddr !== ADDR_W'(v.row)) fldOk = 0;
      if (off == tRw && (cmdAddr !== ADDR_W'(v.col) || cmdBurst !== v.burst)) fldOk = 0;
    end
    chk(seqOk, req, $sformatf("vec%0d command schedule", idx), badGot, badExp);
    chk(oneOk, "R9", $sformatf("vec%0d single command", idx), 0, 0);
    if (!v.refresh) chk(fldOk, "R8", $sformatf("vec%0d bank/addr/burst", idx), cmdAddr, 0);
    chk(busyOk, "R6", $sformatf("vec%0d ready low while busy", idx), 1, 0);
    step();
    chk(reqReady === 1'b1 && cmdVec === 6'b0, "R6", $sformatf("vec%0d ready after done", idx),
        {reqReady, cmdVec}, 7'b1000000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t d;
    bit quiet;
    repeat (3) @(negedge clk);
    #1;
    chk(reqReady === 1'b1 && cmdVec === 6'b0, "R11", "in reset", {reqReady, cmdVec}, 7'b1000000);
    rstN = 1'b1;
    step();
    chk(reqReady === 1'b1 && cmdVec === 6'b0, "R11", "after reset", {reqReady, cmdVec}, 7'b1000000);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], i);

    // R5: enables withheld, chain must stall and go the cycle they rise
    d = '{1'b0, 1'b1, 2'd2, 2'd2, 13'h0444, 10'h099, 3'd6};
    enPre = 4'b1011; enAct = 4'b0000; enWrite = 4'b1011;
    step();
    driveReq(d);
    quiet = 1;
    for (int k = 0; k < 5; k++) begin
      step();
      reqValid = 1'b0;
      if (cmdVec !== 6'b0) quiet = 0;
    end
    chk(quiet, "R5", "no precharge while bank enable low", 1, 0);
    @(negedge clk); enPre = 4'hF; #1;
    chk(cmdVec === 6'b100000 && cmdBank === 2'd2, "R5", "precharge when enable rises",
        cmdVec, 6'b100000);
    quiet = 1;
    for (int k = 0; k < TRP + 3; k++) begin
      step();
      if (cmdVec !== 6'b0) quiet = 0;
    end
    chk(quiet, "R5", "activate held by enable", 1, 0);
    @(negedge clk); enAct = 4'hF; #1;
    chk(cmdVec === 6'b001000 && cmdAddr === 13'h0444, "R5", "activate when enable rises",
        cmdVec, 6'b001000);
    quiet = 1;
    for (int k = 0; k < TRCD + 2; k++) begin
      step();
      if (cmdVec !== 6'b0) quiet = 0;
    end
    chk(quiet, "R5", "write held by other-bank-only enable", 1, 0);
    @(negedge clk); enWrite = 4'hF; #1;
    chk(cmdVec === 6'b000010 && cmdBurst === 3'd6, "R5", "write when enable rises",
        cmdVec, 6'b000010);
    step();
    chk(reqReady === 1'b1, "R6", "ready after stalled chain", reqReady, 1);

    // R10: clear in the middle of a chain
    d = '{1'b0, 1'b0, 2'd2, 2'd0, 13'h0010, 10'h020, 3'd0};
    step();
    driveReq(d);
    step(); reqValid = 1'b0;
    chk(cmdVec === 6'b100000, "R10", "precharge before clear", cmdVec, 6'b100000);
    @(negedge clk); clr = 1'b1; #1;
    chk(cmdVec === 6'b0 && reqReady === 1'b0, "R10", "commands masked during clear",
        {reqReady, cmdVec}, 0);
    @(negedge clk); clr = 1'b0; #1;
    chk(reqReady === 1'b1 && cmdVec === 6'b0, "R10", "idle after clear",
        {reqReady, cmdVec}, 7'b1000000);
    d = '{1'b0, 1'b1, 2'd0, 2'd1, 13'h0000, 10'h0AB, 3'd2};
    driveReq(d);
    step(); reqValid = 1'b0;
    chk(cmdVec === 6'b000010 && cmdAddr === 13'h00AB && cmdBank === 2'd1, "R10",
        "rw-only request issues at once after clear", cmdVec, 6'b000010);
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule